// File: doc/BRIEF.md
# IF Frequency Window Counter

This block decides whether an intermediate-frequency signal sits inside an acceptance band around its expected value. A base timer divides the crystal clock by a programmable ratio. A second stage stretches that base period into a gate made of a power-of-two number of base periods. During the gate a down-counter, loaded with the expected number of IF cycles, loses one count for each rising edge on the IF input. When the gate closes, the counter's residue is treated as a signed error. The block raises a one-cycle done strobe and sets an in-window flag when the error magnitude is small enough.

The measurement repeats without a gap. The counter reloads on the same clock edge that ends a gate. The operating mode selects the nominal count per base period, for FM, AM or AM up-conversion. A five-bit trim moves the centre of the window. A three-bit field sets the width of the window. The counter runs at a short or a long length, chosen from the expected count, and its residue wraps at that length. The IF input is a logic-level signal that is already synchronous to the crystal clock.

Top module: `ifwc_top`

## Requirements
- R1: The mode field selects the nominal count per base period. Code 2'b01 selects FM_NOM, 2'b10 selects AM_NOM and 2'b11 selects UPC_NOM. Code 2'b00 holds the block idle, and done_o never asserts in that mode.
- R2: The base timer produces one tick every base_div+1 clock cycles. A gate lasts 2^gate_sel ticks, so consecutive done_o pulses are exactly (base_div+1)·2^gate_sel cycles apart.
- R3: The counter preset is the nominal count shifted left by gate_sel, plus the trim value of R10.
- R4: During a gate, each clock cycle in which if_in is 1 after a cycle in which it was 0 decrements the counter by one. The residue at the end of the gate is the preset minus the number of such edges.
- R5: The counter uses SHORT_W bits when the shifted nominal count is below 2^(SHORT_W-1), and LONG_W bits otherwise. The residue wraps modulo 2^width, and its top bit is the sign.
- R6: At the end of each gate, inwin_o becomes 1 exactly when the absolute value of the signed residue is at most 2^win_sel. inwin_o holds its value between done_o pulses.
- R7: done_o is a single-cycle pulse issued on the edge that closes a gate. The counter reloads on that same edge, and the next gate starts at once.
- R8: A change of mode, gate_sel or cf_trim abandons the gate in progress without a done_o pulse and starts a new gate on the following edge. The next done_o therefore comes one full gate length after that restart.
- R9: While rst_n is low, done_o and inwin_o are 0.
- R10: cf_trim[3:0] is a two's-complement count offset in the range −8..+7. When cf_trim[4] is 1, that offset is multiplied by 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_in | input | 1 | IF pulse input, synchronous to clk |
| mode | input | 2 | Operating mode (R1 encoding) |
| gate_sel | input | 3 | Gate length exponent, 2^gate_sel base periods |
| win_sel | input | 3 | Window width exponent |
| cf_trim | input | 5 | Centre-frequency trim (R10) |
| base_div | input | BASE_W | Base timer ratio minus one |
| done_o | output | 1 | One-cycle pulse at the end of each gate |
| inwin_o | output | 1 | Last measurement was inside the window |

## Verification
The sweep walks every mode and several gate lengths and window widths. In each case it places the IF edge count just inside, exactly on and just outside both window edges. An off-by-one in the preset, the edge detector or the magnitude compare therefore flips a flag at a boundary. A dedicated overshoot of 70 counts is applied once at the short length and once at the long length. A design that picked the wrong length, or sign-extended from the wrong bit, would report that overshoot on the wrong side of the window. The negative coarse trim is exercised on its own, which catches a trim that is unsigned or scaled wrongly. The bench also measures the gap between done pulses and the delay after a mid-gate reconfiguration. A design that kept the stale gate, dropped a cycle at the reload or leaked a done pulse in idle mode would miss those cycle counts.

// File: rtl/ifwc_pkg.sv
package ifwc_pkg;

    localparam int GS_W = 3;   // gate length exponent width
    localparam int EW_W = 3;   // window exponent width
    localparam int CF_W = 5;   // centre trim width

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_FM  = 2'b01,
        MODE_AM  = 2'b10,
        MODE_UPC = 2'b11
    } ifwc_mode_e;

    typedef struct packed {
        logic [1:0]      mode;
        logic [GS_W-1:0] gs;
        logic [CF_W-1:0] cf;
    } ifwc_cfg_t;

endpackage

// File: rtl/ifwc_base_timer.sv
module ifwc_base_timer #(
    parameter int BASE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [BASE_W-1:0] base_div,
    output logic              tick
);

    logic [BASE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        // >= keeps the divider bounded if base_div shrinks mid-count
        tick  = !clear && (cnt_q >= base_div);
        cnt_d = (clear || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ifwc_preset.sv
module ifwc_preset
    import ifwc_pkg::*;
#(
    parameter int SHORT_W = 11,
    parameter int LONG_W  = 21,
    parameter int FM_NOM  = 1712,
    parameter int AM_NOM  = 450,
    parameter int UPC_NOM = 10700
) (
    input  logic [1:0]        mode,
    input  logic [GS_W-1:0]   gate_sel,
    input  logic [CF_W-1:0]   cf_trim,
    output logic [LONG_W-1:0] preset_o,
    output logic              is_short_o
);

    localparam logic [LONG_W-1:0] SHORT_MASK =
        {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
    localparam logic [LONG_W-1:0] SHORT_LIMIT = LONG_W'(1) << (SHORT_W - 1);

    logic [LONG_W-1:0] nom, shifted, trim_fine, trim, sum;

    always_comb begin
        case (ifwc_mode_e'(mode))
            MODE_FM:  nom = LONG_W'(FM_NOM);
            MODE_AM:  nom = LONG_W'(AM_NOM);
            MODE_UPC: nom = LONG_W'(UPC_NOM);
            default:  nom = '0;
        endcase
        shifted    = nom << gate_sel;
        trim_fine  = {{(LONG_W-4){cf_trim[3]}}, cf_trim[3:0]};
        trim       = cf_trim[4] ? (trim_fine << 4) : trim_fine;
        sum        = shifted + trim;
        is_short_o = shifted < SHORT_LIMIT;
        preset_o   = is_short_o ? (sum & SHORT_MASK) : sum;
    end

endmodule

// File: rtl/ifwc_window.sv
module ifwc_window
    import ifwc_pkg::*;
#(
    parameter int SHORT_W = 11,
    parameter int LONG_W  = 21
) (
    input  logic [LONG_W-1:0] residue,
    input  logic              is_short,
    input  logic [EW_W-1:0]   win_sel,
    output logic              inwin
);

    logic [LONG_W-1:0] r_ext, mag, limit;

    always_comb begin
        r_ext = is_short
              ? {{(LONG_W-SHORT_W){residue[SHORT_W-1]}}, residue[SHORT_W-1:0]}
              : residue;
        mag   = r_ext[LONG_W-1] ? (~r_ext + 1'b1) : r_ext;
        limit = LONG_W'(1) << win_sel;
        inwin = mag <= limit;
    end

endmodule

// File: rtl/ifwc_top.sv
module ifwc_top
    import ifwc_pkg::*;
#(
    parameter int BASE_W  = 14,
    parameter int SHORT_W = 11,
    parameter int LONG_W  = 21,
    parameter int FM_NOM  = 1712,
    parameter int AM_NOM  = 450,
    parameter int UPC_NOM = 10700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_in,
    input  logic [1:0]        mode,
    input  logic [2:0]        gate_sel,
    input  logic [2:0]        win_sel,
    input  logic [4:0]        cf_trim,
    input  logic [BASE_W-1:0] base_div,
    output logic              done_o,
    output logic              inwin_o
);

    localparam int TICK_W = (1 << GS_W) - 1;
    localparam logic [LONG_W-1:0] SHORT_MASK =
        {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    typedef struct packed {
        logic              run;
        logic              if_prev;
        logic [TICK_W-1:0] ticks;
        logic [LONG_W-1:0] cnt;
        ifwc_cfg_t         cfg;
        logic              done;
        logic              inwin;
    } st_t;

    st_t s_d, s_q;

    ifwc_cfg_t         cfg_now;
    logic              tick, timer_clear, is_short, win_ok;
    logic              idle, load, if_rise, gate_end;
    logic [LONG_W-1:0] preset, cnt_dec, cnt_next;
    logic [TICK_W-1:0] tick_last;

    assign cfg_now = '{mode: mode, gs: gate_sel, cf: cf_trim};

    ifwc_base_timer #(.BASE_W(BASE_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (timer_clear),
        .base_div (base_div),
        .tick     (tick)
    );

    ifwc_preset #(
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W),
        .FM_NOM  (FM_NOM),
        .AM_NOM  (AM_NOM),
        .UPC_NOM (UPC_NOM)
    ) u_preset (
        .mode       (mode),
        .gate_sel   (gate_sel),
        .cf_trim    (cf_trim),
        .preset_o   (preset),
        .is_short_o (is_short)
    );

    ifwc_window #(
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) u_window (
        .residue  (cnt_next),
        .is_short (is_short),
        .win_sel  (win_sel),
        .inwin    (win_ok)
    );

    always_comb begin
        idle        = ifwc_mode_e'(mode) == MODE_OFF;
        load        = !s_q.run || (cfg_now != s_q.cfg);
        timer_clear = idle || load;
        if_rise     = if_in && !s_q.if_prev;
        tick_last   = (TICK_W'(1) << gate_sel) - 1'b1;
        gate_end    = tick && (s_q.ticks == tick_last);
        cnt_dec     = s_q.cnt - LONG_W'(if_rise);
        cnt_next    = is_short ? (cnt_dec & SHORT_MASK) : cnt_dec;

        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.if_prev = if_in;
        s_d.cfg     = cfg_now;

        if (idle) begin
            s_d.run   = 1'b0;
            s_d.ticks = '0;
        end else if (load) begin
            s_d.run   = 1'b1;
            s_d.cnt   = preset;
            s_d.ticks = '0;
        end else if (gate_end) begin
            s_d.done  = 1'b1;
            s_d.inwin = win_ok;
            s_d.cnt   = preset;
            s_d.ticks = '0;
        end else begin
            s_d.cnt = cnt_next;
            if (tick) s_d.ticks = s_q.ticks + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o  = s_q.done;
    assign inwin_o = s_q.inwin;

endmodule

// File: rtl/ifwc_chk.sv
module ifwc_chk #(
    parameter int BASE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [2:0]        gate_sel,
    input logic [4:0]        cf_trim,
    input logic [BASE_W-1:0] base_div,
    input logic              done_o,
    input logic              inwin_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> !done_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && base_div != '0) |=> (!done_o || base_div == '0));

    assert_inwin_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(inwin_o));

    assert_restart_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mode, gate_sel, cf_trim}) |=> !done_o);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !inwin_o));

endmodule

bind ifwc_top ifwc_chk #(.BASE_W(BASE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .gate_sel (gate_sel),
    .cf_trim  (cf_trim),
    .base_div (base_div),
    .done_o   (done_o),
    .inwin_o  (inwin_o)
);

// File: tb/tb_ifwc_top.sv
module tb_ifwc_top;

    localparam int BASE_W  = 14;
    localparam int SHORT_W = 7;
    localparam int LONG_W  = 12;
    localparam int FM_NOM  = 12;
    localparam int AM_NOM  = 5;
    localparam int UPC_NOM = 24;
    localparam int DIV     = 127;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              if_in = 1'b0;
    logic [1:0]        mode = 2'b01;
    logic [2:0]        gate_sel = 3'd0;
    logic [2:0]        win_sel = 3'd0;
    logic [4:0]        cf_trim = 5'd0;
    logic [BASE_W-1:0] base_div = BASE_W'(DIV);
    logic              done_o, inwin_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    ifwc_top #(
        .BASE_W (BASE_W), .SHORT_W (SHORT_W), .LONG_W (LONG_W),
        .FM_NOM (FM_NOM), .AM_NOM (AM_NOM), .UPC_NOM (UPC_NOM)
    ) dut (
        .clk (clk), .rst_n (rst_n), .if_in (if_in), .mode (mode),
        .gate_sel (gate_sel), .win_sel (win_sel), .cf_trim (cf_trim),
        .base_div (base_div), .done_o (done_o), .inwin_o (inwin_o)
    );

    task automatic chk(input int got, input int exp, input string req);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic int nominal(input int m);
        return (m == 1) ? FM_NOM : (m == 2) ? AM_NOM : UPC_NOM;
    endfunction

    // R3 and R10: preset from nominal, gate exponent and trim
    function automatic int exp_preset(input int m, input int gs, input logic [4:0] cf);
        int t = int'(cf[3:0]);
        if (t > 7) t -= 16;
        if (cf[4]) t *= 16;
        return (nominal(m) << gs) + t;
    endfunction

    function automatic bit exp_short(input int m, input int gs);
        return (nominal(m) << gs) < (1 << (SHORT_W - 1));
    endfunction

    // R5 and R6: wrap at the selected width, signed magnitude test
    function automatic int exp_inwin(input int p, input int n, input int ew, input bit sh);
        int w = sh ? SHORT_W : LONG_W;
        int r = (p - n) & ((1 << w) - 1);
        if (r >= (1 << (w - 1))) r -= (1 << w);
        if (r < 0) r = -r;
        return (r <= (1 << ew)) ? 1 : 0;
    endfunction

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    task automatic drive_edges(input int n);
        for (int i = 0; i < n; i++) begin
            if_in = 1'b1;
            @(negedge clk);
            if_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic configure(input int m, input int gs, input int ew, input logic [4:0] cf);
        mode     = 2'(m);
        gate_sel = 3'(gs);
        win_sel  = 3'(ew);
        cf_trim  = cf;
        wait_done();
    endtask

    // one gate with n edges; caller sits on a done negedge
    task automatic measure(input int m, input int gs, input int ew,
                           input logic [4:0] cf, input int n, input string req);
        drive_edges(n);
        wait_done();
        chk(int'(inwin_o), exp_inwin(exp_preset(m, gs, cf), n, ew, exp_short(m, gs)), req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int offs[9] = '{-5, -4, -3, -1, 0, 1, 3, 4, 5};
        logic [4:0] cfs[3] = '{5'b00000, 5'b00011, 5'b01110};
        int n;

        // R9: quiet outputs under reset
        repeat (3) @(negedge clk);
        chk(int'(done_o), 0, "R9 done in reset");
        chk(int'(inwin_o), 0, "R9 inwin in reset");
        rst_n = 1'b1;

        // R1: mode 2'b00 never produces done
        mode = 2'b00;
        n = 0;
        repeat (1000) begin
            @(negedge clk);
            if (done_o) n++;
        end
        chk(n, 0, "R1 idle done count");

        // R2 and R7: done spacing and pulse width
        configure(1, 1, 0, 5'd0);
        n = 0;
        do begin @(negedge clk); n++; end while (!done_o);
        chk(n, (DIV + 1) * 2, "R2 done period");
        @(negedge clk);
        chk(int'(done_o), 0, "R7 done width");

        // R8: mid-gate trim change restarts the gate
        repeat (40) @(negedge clk);
        cf_trim = 5'd1;
        n = 0;
        do begin @(negedge clk); n++; end while (!done_o);
        chk(n, (DIV + 1) * 2 + 1, "R8 restart delay");

        // R1/R3/R4/R6: sweep modes, gate lengths, windows, edge counts
        for (int m = 1; m <= 3; m++) begin
            for (int gs = 0; gs <= 2; gs++) begin
                for (int e = 0; e <= 2; e += 2) begin
                    configure(m, gs, e, cfs[m-1]);
                    for (int k = 0; k < 9; k++) begin
                        measure(m, gs, e, cfs[m-1],
                                exp_preset(m, gs, cfs[m-1]) + offs[k], "R1/R3/R4/R6 sweep");
                    end
                end
            end
        end

        // R5: overshoot of 70 wraps to +58 at the short width (inside 64)
        configure(2, 1, 6, 5'd0);
        measure(2, 1, 6, 5'd0, 80, "R5 short wrap");
        chk(int'(inwin_o), 1, "R5 short wrap value");
        // R5: same overshoot at the long width stays -70 (outside 64)
        configure(3, 2, 6, 5'd0);
        measure(3, 2, 6, 5'd0, 166, "R5 long width");
        chk(int'(inwin_o), 0, "R5 long width value");

        // R10: coarse negative trim, preset 20 - 16 = 4
        configure(2, 2, 0, 5'b11111);
        measure(2, 2, 0, 5'b11111, 4, "R10 coarse trim exact");
        chk(int'(inwin_o), 1, "R10 coarse trim exact value");
        measure(2, 2, 0, 5'b11111, 3, "R10 coarse trim -1");
        measure(2, 2, 0, 5'b11111, 6, "R10 coarse trim +2");
        chk(int'(inwin_o), 0, "R10 coarse trim +2 value");

        finish_run();
    end

endmodule